// File: doc/BRIEF.md
# I2C Master SCL Period Generator

This block produces the serial clock of an I2C master from the system clock. A 16-bit configuration word holds two independent counts, one for the time SCL is released (high) and one for the time it is driven low. Each phase lasts its count plus one system clock. Counts below a floor are raised to that floor when they are used, so the line is never toggled faster than the surrounding master logic can handle.

While enabled, the block alternates between a high phase and a low phase. On the last cycle of every phase it raises a one-cycle phase strobe, so that a bit sequencer can change SDA at a known point. On the last cycle of each low phase it also raises a bit strobe. A complete bit is one high phase followed by one low phase.

The generator watches the real line through `scl_in`. If a slave holds SCL low while the block has released it, the high phase does not advance until the line reads high. When `enable` is low, SCL is released and both phase counters stay at zero.

Three states are used: `PH_IDLE` (disabled, line released), `PH_HIGH` (line released, counting high time) and `PH_LOW` (line driven low, counting low time). The transitions are as follows:

- IDLE→HIGH happens when enable is seen.
- HIGH→LOW happens when the high count completes.
- LOW→HIGH happens when the low count completes.
- HIGH→IDLE and LOW→IDLE happen when enable drops.

Top module: `scl_pacer`

## Requirements
- R1: After reset the configuration word reads 0x0204, `scl_out` is 1 and both strobes are 0. An enable with no write then gives a high phase of 3 cycles and a low phase of 5 cycles.
- R2: A write with `cfg_we` high stores `cfg_wdata` on the next clock edge. Bits 15:8 are the high field and bits 7:0 are the low field. `cfg_rdata` returns the stored word unaltered, including field values below the floors.
- R3: A high phase lasts max(high field, 2) + 1 system clocks when the line is not held low.
- R4: A low phase lasts max(low field, 4) + 1 system clocks.
- R5: The first phase after `enable` is seen high is a full high phase. It starts on the clock edge that samples `enable`.
- R6: A field is taken from the configuration word only on the edge that starts its phase. A write during a phase changes only later phases.
- R7: While in the high phase, any cycle in which `scl_in` reads 0 holds the high counter at its start value. The phase therefore lasts (stretched cycles) + max(high field, 2) + 1 cycles.
- R8: On the edge that samples `enable` low, `scl_out` goes to 1 and the strobes stay 0 while disabled. The counters restart from zero, so the next enable gives a full high phase.
- R9: `edge_strobe` is 1 on exactly the last cycle of each high and each low phase. `scl_out` changes on the following edge.
- R10: `bit_strobe` is 1 only on the last cycle of a low phase, so each bit has exactly one bit strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the SCL generator |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word: high field in [15:8], low field in [7:0] |
| cfg_rdata | output | 16 | Stored configuration word |
| scl_in | input | 1 | Synchronised level of the SCL line |
| scl_out | output | 1 | 1 = release SCL, 0 = drive SCL low |
| edge_strobe | output | 1 | Last cycle of a phase |
| bit_strobe | output | 1 | Last cycle of a low phase (bit end) |

## Verification
The assertions assume that `scl_in` is already synchronised to `clk`. They also assume that `scl_in` reads low only when the block or another device holds the line, so it never reads low while the block drives high without cause. The stimulus models the line as `scl_out` AND NOT a stretch request, and drives all inputs on the falling clock edge. The sweep writes the configuration only while disabled, except in the test that writes mid-phase on purpose.

// File: rtl/scl_pacer_pkg.sv
package scl_pacer_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    localparam int unsigned PHASE_COUNT = 2;
    localparam int unsigned IDX_HIGH    = 0;
    localparam int unsigned IDX_LOW     = 1;

endpackage

// File: rtl/scl_cfg_reg.sv
module scl_cfg_reg #(
    parameter int unsigned FIELD_W  = 8,
    parameter int unsigned HI_MIN   = 2,
    parameter int unsigned LO_MIN   = 4,
    parameter int unsigned HI_RESET = 2,
    parameter int unsigned LO_RESET = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic [2*FIELD_W-1:0] wdata_i,
    output logic [2*FIELD_W-1:0] rdata_o,
    output logic [FIELD_W-1:0]   hi_eff_o,
    output logic [FIELD_W-1:0]   lo_eff_o
);
    localparam int unsigned CFG_W = 2 * FIELD_W;

    logic [CFG_W-1:0]   word_q;
    logic [FIELD_W-1:0] hi_raw;
    logic [FIELD_W-1:0] lo_raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= {FIELD_W'(HI_RESET), FIELD_W'(LO_RESET)};
        end else if (we_i) begin
            word_q <= wdata_i;
        end
    end

    always_comb begin
        hi_raw   = word_q[CFG_W-1:FIELD_W];
        lo_raw   = word_q[FIELD_W-1:0];
        hi_eff_o = (hi_raw < FIELD_W'(HI_MIN)) ? FIELD_W'(HI_MIN) : hi_raw;
        lo_eff_o = (lo_raw < FIELD_W'(LO_MIN)) ? FIELD_W'(LO_MIN) : lo_raw;
        rdata_o  = word_q;
    end

    // R2
    cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> rdata_o == $past(wdata_i));

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
    parameter int unsigned FIELD_W = 8,
    parameter int unsigned MIN_LIM = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FIELD_W-1:0] lim_i,
    input  logic               active_i,
    input  logic               stall_i,
    output logic               done_o
);
    logic [FIELD_W-1:0] cnt_q;
    logic [FIELD_W-1:0] lim_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= FIELD_W'(MIN_LIM);
        end else if (load_i) begin
            cnt_q <= '0;
            lim_q <= lim_i;
        end else if (!active_i || stall_i || done_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = active_i && !stall_i && (cnt_q == lim_q);

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !stall_i && !load_i && !done_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R4
    lim_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (lim_q >= FIELD_W'(MIN_LIM)));

endmodule

// File: rtl/scl_pacer.sv
module scl_pacer
    import scl_pacer_pkg::*;
#(
    parameter int unsigned FIELD_W  = 8,
    parameter int unsigned HI_MIN   = 2,
    parameter int unsigned LO_MIN   = 4,
    parameter int unsigned HI_RESET = 2,
    parameter int unsigned LO_RESET = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 cfg_we,
    input  logic [2*FIELD_W-1:0] cfg_wdata,
    output logic [2*FIELD_W-1:0] cfg_rdata,
    input  logic                 scl_in,
    output logic                 scl_out,
    output logic                 edge_strobe,
    output logic                 bit_strobe
);
    localparam int unsigned CFG_W = 2 * FIELD_W;

    phase_e             state_q;
    phase_e             state_d;
    logic [FIELD_W-1:0] hi_eff;
    logic [FIELD_W-1:0] lo_eff;
    logic               load   [PHASE_COUNT];
    logic [FIELD_W-1:0] lim    [PHASE_COUNT];
    logic               active [PHASE_COUNT];
    logic               stall  [PHASE_COUNT];
    logic               done   [PHASE_COUNT];

    scl_cfg_reg #(
        .FIELD_W (FIELD_W),
        .HI_MIN  (HI_MIN),
        .LO_MIN  (LO_MIN),
        .HI_RESET(HI_RESET),
        .LO_RESET(LO_RESET)
    ) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .wdata_i (cfg_wdata[CFG_W-1:0]),
        .rdata_o (cfg_rdata),
        .hi_eff_o(hi_eff),
        .lo_eff_o(lo_eff)
    );

    assign lim[IDX_HIGH]    = hi_eff;
    assign lim[IDX_LOW]     = lo_eff;
    assign active[IDX_HIGH] = (state_q == PH_HIGH);
    assign active[IDX_LOW]  = (state_q == PH_LOW);
    assign stall[IDX_HIGH]  = !scl_in;
    assign stall[IDX_LOW]   = 1'b0;

    for (genvar g = 0; g < PHASE_COUNT; g++) begin : g_timer
        scl_phase_timer #(
            .FIELD_W(FIELD_W),
            .MIN_LIM((g == IDX_HIGH) ? HI_MIN : LO_MIN)
        ) timer_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (load[g]),
            .lim_i   (lim[g]),
            .active_i(active[g]),
            .stall_i (stall[g]),
            .done_o  (done[g])
        );
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and timer loads
    always_comb begin
        state_d        = state_q;
        load[IDX_HIGH] = 1'b0;
        load[IDX_LOW]  = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                if (enable) begin
                    state_d        = PH_HIGH;
                    load[IDX_HIGH] = 1'b1;
                end
            end
            PH_HIGH: begin
                if (!enable) begin
                    state_d = PH_IDLE;
                end else if (done[IDX_HIGH]) begin
                    state_d       = PH_LOW;
                    load[IDX_LOW] = 1'b1;
                end
            end
            PH_LOW: begin
                if (!enable) begin
                    state_d = PH_IDLE;
                end else if (done[IDX_LOW]) begin
                    state_d        = PH_HIGH;
                    load[IDX_HIGH] = 1'b1;
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        scl_out     = (state_q != PH_LOW);
        edge_strobe = done[IDX_HIGH] || done[IDX_LOW];
        bit_strobe  = done[IDX_LOW];
    end

    // R9
    edge_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_strobe && enable) |=> (scl_out != $past(scl_out)));

    // R10
    bit_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> (edge_strobe && !scl_out));

    // R8
    disable_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_out && !edge_strobe));

    // R7
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !scl_in && scl_out && state_q == PH_HIGH) |=> scl_out);

endmodule

// File: tb/scl_pacer_tb_top.sv
`timescale 1ns/1ps
module scl_pacer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        scl_out;
    logic        edge_strobe;
    logic        bit_strobe;
    logic        hold_low = 1'b0;
    logic        scl_in;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    assign scl_in = scl_out & ~hold_low;

    scl_pacer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .scl_in     (scl_in),
        .scl_out    (scl_out),
        .edge_strobe(edge_strobe),
        .bit_strobe (bit_strobe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff(input int v, input int floor_v);
        return ((v < floor_v) ? floor_v : v) + 1;
    endfunction

    // counts consecutive negedge samples with scl_out == v, starting at the current one
    task automatic run_len(input logic v, output int n, output int edges,
                           output int bits, output bit last_edge, output bit last_bit);
        n = 0; edges = 0; bits = 0; last_edge = 0; last_bit = 0;
        while (scl_out == v && n < 4000) begin
            n++;
            edges += int'(edge_strobe);
            bits  += int'(bit_strobe);
            last_edge = edge_strobe;
            last_bit  = bit_strobe;
            @(negedge clk);
        end
    endtask

    task automatic write_cfg(input logic [15:0] w);
        cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic sweep_one(input int h, input int l);
        int n, e, b;
        bit le, lb;
        enable = 1'b0;
        @(negedge clk);
        write_cfg({h[7:0], l[7:0]});
        chk(cfg_rdata == {h[7:0], l[7:0]}, "R2 readback", cfg_rdata, {h[7:0], l[7:0]});
        enable = 1'b1;
        @(negedge clk);
        run_len(1'b1, n, e, b, le, lb);
        chk(n == eff(h, 2), "R5 first high phase length", n, eff(h, 2));
        chk(e == 1 && le, "R9 high phase strobe", e, 1);
        chk(b == 0, "R10 no bit strobe in high", b, 0);
        run_len(1'b0, n, e, b, le, lb);
        chk(n == eff(l, 4), "R4 low phase length", n, eff(l, 4));
        chk(e == 1 && le, "R9 low phase strobe", e, 1);
        chk(b == 1 && lb, "R10 bit strobe at low end", b, 1);
        run_len(1'b1, n, e, b, le, lb);
        chk(n == eff(h, 2), "R3 high phase length", n, eff(h, 2));
        enable = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int n, e, b;
        bit le, lb;
        int hv[7] = '{0, 1, 2, 3, 4, 7, 40};
        int lv[6] = '{0, 3, 4, 5, 9, 100};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_rdata == 16'h0204, "R1 reset word", cfg_rdata, 16'h0204);
        chk(scl_out == 1'b1, "R1 reset scl", scl_out, 1);
        chk(!edge_strobe && !bit_strobe, "R1 reset strobes", {edge_strobe, bit_strobe}, 0);
        enable = 1'b1;
        @(negedge clk);
        run_len(1'b1, n, e, b, le, lb);
        chk(n == 3, "R1 default high", n, 3);
        run_len(1'b0, n, e, b, le, lb);
        chk(n == 5, "R1 default low", n, 5);
        enable = 1'b0;
        @(negedge clk);

        // sweep of both fields around and above the floors
        foreach (hv[i]) begin
            foreach (lv[j]) begin
                sweep_one(hv[i], lv[j]);
            end
        end

        // R7 stretched high phase
        write_cfg(16'h0304);
        enable = 1'b1;
        @(negedge clk);
        run_len(1'b1, n, e, b, le, lb);
        run_len(1'b0, n, e, b, le, lb);
        hold_low = 1'b1;
        n = 0; e = 0;
        while (scl_out == 1'b1 && n < 4000) begin
            n++;
            e += int'(edge_strobe);
            if (n == 7) hold_low = 1'b0;
            @(negedge clk);
        end
        hold_low = 1'b0;
        chk(n == 6 + 4, "R7 stretched high length", n, 10);
        chk(e == 1, "R7 single strobe in stretched high", e, 1);
        run_len(1'b0, n, e, b, le, lb);
        chk(n == 5, "R7 low after stretch", n, 5);
        enable = 1'b0;
        @(negedge clk);

        // R6 write in the middle of a low phase
        write_cfg(16'h0304);
        enable = 1'b1;
        @(negedge clk);
        run_len(1'b1, n, e, b, le, lb);
        n = 0;
        while (scl_out == 1'b0 && n < 4000) begin
            n++;
            if (n == 2) begin cfg_we = 1'b1; cfg_wdata = 16'h0608; end
            else cfg_we = 1'b0;
            @(negedge clk);
        end
        cfg_we = 1'b0;
        chk(n == 5, "R6 current low unchanged", n, 5);
        run_len(1'b1, n, e, b, le, lb);
        chk(n == 7, "R6 next high uses new field", n, 7);
        run_len(1'b0, n, e, b, le, lb);
        chk(n == 9, "R6 next low uses new field", n, 9);
        enable = 1'b0;
        @(negedge clk);

        // R8 disable mid low, then fresh restart
        write_cfg(16'h0506);
        enable = 1'b1;
        @(negedge clk);
        run_len(1'b1, n, e, b, le, lb);
        @(negedge clk);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(scl_out == 1'b1, "R8 released after disable", scl_out, 1);
        e = 0; b = 0;
        for (int k = 0; k < 10; k++) begin
            if (!scl_out) b++;
            e += int'(edge_strobe) + int'(bit_strobe);
            @(negedge clk);
        end
        chk(b == 0, "R8 stays released", b, 0);
        chk(e == 0, "R8 strobes silent", e, 0);
        enable = 1'b1;
        @(negedge clk);
        run_len(1'b1, n, e, b, le, lb);
        chk(n == 6, "R8 fresh high after re-enable", n, 6);
        run_len(1'b0, n, e, b, le, lb);
        chk(n == 7, "R8 low after re-enable", n, 7);
        enable = 1'b0;
        @(negedge clk);

        done_flag = 1'b1;
    end

    initial begin
        fork
            wait (done_flag);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule